// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is a multiply-accumulate datapath for a processor. Each operation takes two 32-bit operands and picks one 16-bit half of each. It treats the two halves as signed values and multiplies them. The product then either replaces a 40-bit accumulator, is added to it, or is subtracted from it. Software reads and writes the accumulator as two 32-bit words: a low word and a sign-extended high word.

Each operand comes either from a general-register value supplied on the ports or from a small local file of operand registers. The operand registers can be written directly. They can also be loaded from memory through a pointer that steps up or down by one word before the access. The block returns the updated pointer for write-back. A load can be issued alone or in the same cycle as a multiply. Instruction decode, hazard handling and exceptions are left to the surrounding pipeline.

Top module: `mac16_unit`

## Requirements
- R1: After reset, the accumulator reads as zero in both words and every operand register reads as zero.
- R2: `x_hi`/`y_hi` select a half of each operand. A value of 0 takes bits 15:0 and a value of 1 takes bits 31:16. All four pairings give their own product.
- R3: Both selected halves are two's-complement 16-bit values. The product is signed and is sign-extended to 40 bits.
- R4: `mul_op` = 0 with `mul_en` loads the accumulator with the product. The result is visible on `acc_lo`/`acc_hi` after the next rising clock edge.
- R5: `mul_op` = 1 adds the product to the accumulator modulo 2^40, with no saturation.
- R6: `mul_op` = 2 subtracts the product from the accumulator modulo 2^40.
- R7: `acc_lo` is accumulator bits 31:0. `acc_hi` is bits 39:32, sign-extended from bit 7 to 32 bits. A write through `acc_hi_we` keeps only `acc_wdata[7:0]` and leaves the low word unchanged.
- R8: Each operand comes from its general-register port when its `*_use_oreg` bit is 0, or from operand register `*_oreg_idx` when that bit is 1.
- R9: An increment load (`ld_en`=1, `ld_dec`=0) drives `mem_addr` = `ptr_wb` = `ld_ptr`+4 in the same cycle. The word read there appears in operand register `ld_dst` after the second rising edge.
- R10: A decrement load (`ld_dec`=1) uses `ld_ptr`-4 for both the address and the write-back pointer. Its data arrives with the same timing as R9.
- R11: When a multiply and a load are issued in the same cycle, the multiply uses the operand register value from before the load. This holds even when the load targets that same register.
- R12: The accumulator holds its value when `mul_op` = 3 or `mul_en` is 0 and no word write is requested. Word writes are ignored in a cycle where a multiply writes the accumulator.
- R13: When load data lands in the same cycle as a direct `oreg_we` write to the same register, the load data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_en | input | 1 | Issue a multiply this cycle |
| mul_op | input | 2 | 0 set, 1 add, 2 subtract, 3 keep |
| x_hi | input | 1 | Half select for operand X |
| y_hi | input | 1 | Half select for operand Y |
| x_use_oreg | input | 1 | X comes from an operand register |
| x_oreg_idx | input | 2 | Operand register index for X |
| x_gpr | input | 32 | General-register value for X |
| y_use_oreg | input | 1 | Y comes from an operand register |
| y_oreg_idx | input | 2 | Operand register index for Y |
| y_gpr | input | 32 | General-register value for Y |
| ld_en | input | 1 | Issue a pointer-stepping load |
| ld_dec | input | 1 | 1 steps the pointer down, 0 steps it up |
| ld_ptr | input | 32 | Pointer before the step |
| ld_dst | input | 2 | Operand register to load |
| ptr_wb | output | 32 | Stepped pointer for write-back |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| acc_lo_we | input | 1 | Write accumulator low word |
| acc_hi_we | input | 1 | Write accumulator high byte |
| acc_wdata | input | 32 | Accumulator write data |
| oreg_we | input | 1 | Direct operand register write |
| oreg_widx | input | 2 | Direct write index |
| oreg_wdata | input | 32 | Direct write data |
| oreg_ridx | input | 2 | Operand register read index |
| oreg_rdata | output | 32 | Operand register read data |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 32 | Accumulator bits 39:32, sign-extended |

## Verification
A multiply or accumulator word write changes `acc_lo`/`acc_hi` one rising edge after issue. The bench drives on the falling edge and reads at the next falling edge. The load address and the write-back pointer are combinational, so they are read a short delay after driving and before that edge. Load data reaches the operand register two edges after issue: one edge for the memory and one for the register write. The bench therefore idles one extra cycle before reading `oreg_rdata`. The R13 collision is created by driving the direct write in the cycle between those two edges.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
   typedef enum logic [1:0] {
      ACC_SET  = 2'd0,
      ACC_ADD  = 2'd1,
      ACC_SUB  = 2'd2,
      ACC_KEEP = 2'd3
   } acc_op_e;
endpackage

// File: rtl/mac16_opsel.sv
module mac16_opsel #(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16,
   parameter int N_OREG = 4,
   parameter bit HAS_OREG = 1'b1,
   localparam int IDX_W = $clog2(N_OREG)
) (
   input  logic [OP_W-1:0]        gpr_i,
   input  logic                   use_oreg_i,
   input  logic [IDX_W-1:0]       idx_i,
   input  logic [N_OREG*OP_W-1:0] oregs_i,
   input  logic                   hi_i,
   output logic signed [HALF_W-1:0] half_o
);
   logic [OP_W-1:0] word;

   generate
      if (HAS_OREG) begin : g_oreg
         always_comb begin
            word = gpr_i;
            if (use_oreg_i) word = oregs_i[idx_i*OP_W +: OP_W];
         end
      end else begin : g_gpr_only
         logic unused_sel;
         assign unused_sel = use_oreg_i ^ (^idx_i) ^ (^oregs_i);
         assign word = gpr_i;
      end
   endgenerate

   assign half_o = hi_i ? word[OP_W-1 -: HALF_W] : word[HALF_W-1:0];
endmodule

// File: rtl/mac16_acc.sv
module mac16_acc
   import mac16_pkg::*;
#(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16,
   parameter int ACC_W  = 40,
   localparam int PW    = 2*HALF_W,
   localparam int HI_W  = ACC_W - OP_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mul_en_i,
   input  acc_op_e                  op_i,
   input  logic signed [HALF_W-1:0] x_i,
   input  logic signed [HALF_W-1:0] y_i,
   input  logic                     lo_we_i,
   input  logic                     hi_we_i,
   input  logic [OP_W-1:0]          wdata_i,
   output logic [ACC_W-1:0]         acc_o
);
   logic signed [PW-1:0] prod;
   logic [ACC_W-1:0]     prod_ext;
   logic [ACC_W-1:0]     acc_q;
   logic [ACC_W-1:0]     acc_d;
   logic                 mul_wr;

   assign prod     = x_i * y_i;
   assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
   assign mul_wr   = mul_en_i && (op_i != ACC_KEEP);

   always_comb begin
      acc_d = acc_q;
      if (mul_wr) begin
         case (op_i)
            ACC_SET: acc_d = prod_ext;
            ACC_ADD: acc_d = acc_q + prod_ext;
            ACC_SUB: acc_d = acc_q - prod_ext;
            default: acc_d = acc_q;
         endcase
      end else begin
         if (lo_we_i) acc_d[OP_W-1:0]  = wdata_i;
         if (hi_we_i) acc_d[ACC_W-1:OP_W] = wdata_i[HI_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   assign acc_o = acc_q;

   // R12: no multiply write and no word write keeps the accumulator
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mul_en_i && op_i != ACC_KEEP) && !lo_we_i && !hi_we_i) |=> $stable(acc_q));

   // R7: a high-word write leaves the low word alone
   a_r7_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mul_en_i && op_i != ACC_KEEP) && hi_we_i && !lo_we_i)
      |=> (acc_q[OP_W-1:0] == $past(acc_q[OP_W-1:0])));

   // R12: word writes during a multiply write are dropped
   a_r12_mul_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_en_i && op_i == ACC_SET && lo_we_i && (wdata_i != prod_ext[OP_W-1:0]))
      |=> (acc_q[OP_W-1:0] != $past(wdata_i)));
endmodule

// File: rtl/mac16_oregs.sv
module mac16_oregs #(
   parameter int OP_W   = 32,
   parameter int N_OREG = 4,
   parameter int AW     = 32,
   parameter int STEP   = 4,
   localparam int IDX_W = $clog2(N_OREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we_i,
   input  logic [IDX_W-1:0]       widx_i,
   input  logic [OP_W-1:0]        wdata_i,
   input  logic                   ld_en_i,
   input  logic                   ld_dec_i,
   input  logic [AW-1:0]          ld_ptr_i,
   input  logic [IDX_W-1:0]       ld_dst_i,
   output logic [AW-1:0]          ptr_wb_o,
   output logic                   mem_rd_o,
   output logic [AW-1:0]          mem_addr_o,
   input  logic [OP_W-1:0]        mem_rdata_i,
   input  logic [IDX_W-1:0]       ridx_i,
   output logic [OP_W-1:0]        rdata_o,
   output logic [N_OREG*OP_W-1:0] regs_flat_o
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic [OP_W-1:0]  regs_q [N_OREG];
   logic             pend_q;
   logic [IDX_W-1:0] dst_q;
   logic [AW-1:0]    ptr_new;

   assign ptr_new    = ld_dec_i ? (ld_ptr_i - STEP_V) : (ld_ptr_i + STEP_V);
   assign ptr_wb_o   = ptr_new;
   assign mem_addr_o = ptr_new;
   assign mem_rd_o   = ld_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         dst_q  <= '0;
      end else begin
         pend_q <= ld_en_i;
         if (ld_en_i) dst_q <= ld_dst_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_OREG; i++) regs_q[i] <= '0;
      end else begin
         for (int i = 0; i < N_OREG; i++) begin
            if (pend_q && dst_q == IDX_W'(i))     regs_q[i] <= mem_rdata_i;
            else if (we_i && widx_i == IDX_W'(i)) regs_q[i] <= wdata_i;
         end
      end
   end

   generate
      for (genvar g = 0; g < N_OREG; g++) begin : g_flat
         assign regs_flat_o[g*OP_W +: OP_W] = regs_q[g];
      end
   endgenerate

   assign rdata_o = regs_q[ridx_i];

   // R9/R13: returning load data lands in its register, beating a direct write
   a_r13_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> (regs_q[$past(dst_q)] == $past(mem_rdata_i)));

   // R8: a direct write with no load pending is stored
   a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !pend_q) |=> (regs_q[$past(widx_i)] == $past(wdata_i)));
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
   import mac16_pkg::*;
#(
   parameter int OP_W   = 32,
   parameter int HALF_W = 16,
   parameter int ACC_W  = 40,
   parameter int N_OREG = 4,
   parameter int AW     = 32,
   parameter int STEP   = 4,
   localparam int IDX_W = $clog2(N_OREG),
   localparam int HI_W  = ACC_W - OP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mul_en,
   input  logic [1:0]       mul_op,
   input  logic             x_hi,
   input  logic             y_hi,
   input  logic             x_use_oreg,
   input  logic [IDX_W-1:0] x_oreg_idx,
   input  logic [OP_W-1:0]  x_gpr,
   input  logic             y_use_oreg,
   input  logic [IDX_W-1:0] y_oreg_idx,
   input  logic [OP_W-1:0]  y_gpr,
   input  logic             ld_en,
   input  logic             ld_dec,
   input  logic [AW-1:0]    ld_ptr,
   input  logic [IDX_W-1:0] ld_dst,
   output logic [AW-1:0]    ptr_wb,
   output logic             mem_rd_en,
   output logic [AW-1:0]    mem_addr,
   input  logic [OP_W-1:0]  mem_rdata,
   input  logic             acc_lo_we,
   input  logic             acc_hi_we,
   input  logic [OP_W-1:0]  acc_wdata,
   input  logic             oreg_we,
   input  logic [IDX_W-1:0] oreg_widx,
   input  logic [OP_W-1:0]  oreg_wdata,
   input  logic [IDX_W-1:0] oreg_ridx,
   output logic [OP_W-1:0]  oreg_rdata,
   output logic [OP_W-1:0]  acc_lo,
   output logic [OP_W-1:0]  acc_hi
);
   generate
      if (OP_W != 2*HALF_W) begin : g_bad_half
         $error("OP_W must be twice HALF_W");
      end
      if (ACC_W <= 2*HALF_W || HI_W >= OP_W || HI_W < 1) begin : g_bad_acc
         $error("ACC_W must exceed the product width and fit in two words");
      end
      if (N_OREG < 2) begin : g_bad_oreg
         $error("N_OREG must be at least 2");
      end
   endgenerate

   logic [N_OREG*OP_W-1:0]    regs_flat;
   logic signed [HALF_W-1:0]  x_half;
   logic signed [HALF_W-1:0]  y_half;
   logic [ACC_W-1:0]          acc;

   mac16_oregs #(.OP_W(OP_W), .N_OREG(N_OREG), .AW(AW), .STEP(STEP)) u_oregs (
      .clk(clk), .rst_n(rst_n),
      .we_i(oreg_we), .widx_i(oreg_widx), .wdata_i(oreg_wdata),
      .ld_en_i(ld_en), .ld_dec_i(ld_dec), .ld_ptr_i(ld_ptr), .ld_dst_i(ld_dst),
      .ptr_wb_o(ptr_wb), .mem_rd_o(mem_rd_en), .mem_addr_o(mem_addr),
      .mem_rdata_i(mem_rdata), .ridx_i(oreg_ridx), .rdata_o(oreg_rdata),
      .regs_flat_o(regs_flat)
   );

   mac16_opsel #(.OP_W(OP_W), .HALF_W(HALF_W), .N_OREG(N_OREG)) u_xsel (
      .gpr_i(x_gpr), .use_oreg_i(x_use_oreg), .idx_i(x_oreg_idx),
      .oregs_i(regs_flat), .hi_i(x_hi), .half_o(x_half)
   );

   mac16_opsel #(.OP_W(OP_W), .HALF_W(HALF_W), .N_OREG(N_OREG)) u_ysel (
      .gpr_i(y_gpr), .use_oreg_i(y_use_oreg), .idx_i(y_oreg_idx),
      .oregs_i(regs_flat), .hi_i(y_hi), .half_o(y_half)
   );

   mac16_acc #(.OP_W(OP_W), .HALF_W(HALF_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .mul_en_i(mul_en), .op_i(acc_op_e'(mul_op)),
      .x_i(x_half), .y_i(y_half),
      .lo_we_i(acc_lo_we), .hi_we_i(acc_hi_we), .wdata_i(acc_wdata),
      .acc_o(acc)
   );

   assign acc_lo = acc[OP_W-1:0];
   assign acc_hi = {{(OP_W-HI_W){acc[ACC_W-1]}}, acc[ACC_W-1:OP_W]};

   // R9: an increment load addresses one step above the pointer
   a_r9_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !ld_dec) |-> (mem_rd_en && (mem_addr - ld_ptr) == AW'(STEP) && ptr_wb == mem_addr));

   // R10: a decrement load addresses one step below the pointer
   a_r10_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_dec) |-> (mem_rd_en && (ld_ptr - mem_addr) == AW'(STEP) && ptr_wb == mem_addr));
endmodule

// File: tb/mac16_unit_tb.sv
module mac16_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mul_en = 0;
   logic [1:0]  mul_op = 0;
   logic        x_hi = 0, y_hi = 0;
   logic        x_use_oreg = 0, y_use_oreg = 0;
   logic [1:0]  x_oreg_idx = 0, y_oreg_idx = 0;
   logic [31:0] x_gpr = 0, y_gpr = 0;
   logic        ld_en = 0, ld_dec = 0;
   logic [31:0] ld_ptr = 0;
   logic [1:0]  ld_dst = 0;
   logic [31:0] ptr_wb;
   logic        mem_rd_en;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = 0;
   logic        acc_lo_we = 0, acc_hi_we = 0;
   logic [31:0] acc_wdata = 0;
   logic        oreg_we = 0;
   logic [1:0]  oreg_widx = 0, oreg_ridx = 0;
   logic [31:0] oreg_wdata = 0;
   logic [31:0] oreg_rdata, acc_lo, acc_hi;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] mem [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[5:2]];

   mac16_unit u_dut (
      .clk(clk), .rst_n(rst_n), .mul_en(mul_en), .mul_op(mul_op),
      .x_hi(x_hi), .y_hi(y_hi), .x_use_oreg(x_use_oreg), .x_oreg_idx(x_oreg_idx),
      .x_gpr(x_gpr), .y_use_oreg(y_use_oreg), .y_oreg_idx(y_oreg_idx), .y_gpr(y_gpr),
      .ld_en(ld_en), .ld_dec(ld_dec), .ld_ptr(ld_ptr), .ld_dst(ld_dst),
      .ptr_wb(ptr_wb), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .acc_lo_we(acc_lo_we), .acc_hi_we(acc_hi_we), .acc_wdata(acc_wdata),
      .oreg_we(oreg_we), .oreg_widx(oreg_widx), .oreg_wdata(oreg_wdata),
      .oreg_ridx(oreg_ridx), .oreg_rdata(oreg_rdata), .acc_lo(acc_lo), .acc_hi(acc_hi)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   function automatic logic [39:0] prod40(logic [31:0] a, logic [31:0] b, bit ah, bit bh);
      logic signed [15:0] xa;
      logic signed [15:0] yb;
      longint p;
      xa = ah ? a[31:16] : a[15:0];
      yb = bh ? b[31:16] : b[15:0];
      p = longint'(xa) * longint'(yb);
      return p[39:0];
   endfunction

   task automatic chk_acc(string req, logic [39:0] e);
      chk({req, " lo"}, acc_lo, e[31:0]);
      chk({req, " hi"}, acc_hi, {{24{e[39]}}, e[39:32]});
   endtask

   task automatic idle();
      mul_en = 0; ld_en = 0; oreg_we = 0; acc_lo_we = 0; acc_hi_we = 0;
   endtask

   task automatic set_acc(logic [39:0] v);
      acc_lo_we = 1; acc_wdata = v[31:0]; step();
      acc_lo_we = 0; acc_hi_we = 1; acc_wdata = {24'h5a5a5a, v[39:32]}; step();
      acc_hi_we = 0;
   endtask

   task automatic wr_oreg(logic [1:0] i, logic [31:0] d);
      oreg_we = 1; oreg_widx = i; oreg_wdata = d; step();
      oreg_we = 0;
   endtask

   task automatic read_oreg(string req, logic [1:0] i, logic [31:0] e);
      oreg_ridx = i; #1;
      chk(req, oreg_rdata, e);
   endtask

   // R2 R3 R4 R5 R6 R8: all four half pairings for one op and source pairing
   task automatic t_mul_all(string req, logic [1:0] op, bit xo, bit yo,
                            logic [31:0] a, logic [31:0] b, logic [39:0] iv);
      for (int k = 0; k < 4; k++) begin
         logic [39:0] p, e;
         set_acc(iv);
         p = prod40(a, b, k[1], k[0]);
         e = (op == 2'd0) ? p : (op == 2'd1) ? iv + p : iv - p;
         mul_en = 1; mul_op = op; x_hi = k[1]; y_hi = k[0];
         x_use_oreg = xo; y_use_oreg = yo; x_oreg_idx = 2'd1; y_oreg_idx = 2'd2;
         x_gpr = xo ? 32'hdead0001 : a; y_gpr = yo ? 32'hbeef0002 : b;
         step(); idle();
         chk_acc(req, e);
      end
      x_use_oreg = 0; y_use_oreg = 0;
   endtask

   task automatic t_reset();
      chk_acc("R1 acc after reset", 40'h0);
      for (int i = 0; i < 4; i++) read_oreg("R1 oreg after reset", 2'(i), 32'h0);
   endtask

   task automatic t_hi_word();
      set_acc(40'h00_1357_9bdf);
      acc_hi_we = 1; acc_wdata = 32'h1234_5680; step(); idle();
      chk("R7 hi sign-extended", acc_hi, 32'hffff_ff80);
      chk("R7 lo unchanged", acc_lo, 32'h1357_9bdf);
      acc_hi_we = 1; acc_wdata = 32'hffff_ff7f; step(); idle();
      chk("R7 hi positive", acc_hi, 32'h0000_007f);
   endtask

   task automatic t_wrap();
      set_acc(40'hff_ffff_ffff);
      mul_en = 1; mul_op = 2'd1; x_gpr = 32'h1; y_gpr = 32'h1; x_hi = 0; y_hi = 0;
      step(); idle();
      chk_acc("R5 add wraps", 40'h0);
      mul_en = 1; mul_op = 2'd2; step(); idle();
      chk_acc("R6 sub wraps", 40'hff_ffff_ffff);
   endtask

   task automatic t_keep();
      set_acc(40'h12_3456_789a);
      mul_en = 1; mul_op = 2'd3; x_gpr = 32'h7fff; y_gpr = 32'h7fff; step(); idle();
      chk_acc("R12 keep op", 40'h12_3456_789a);
      step();
      chk_acc("R12 idle hold", 40'h12_3456_789a);
      mul_en = 1; mul_op = 2'd0; x_gpr = 32'h3; y_gpr = 32'hffff_fffe;
      acc_lo_we = 1; acc_hi_we = 1; acc_wdata = 32'h0bad_0bad; step(); idle();
      chk_acc("R12 word write ignored during multiply", 40'hff_ffff_fffa);
   endtask

   task automatic t_load(bit dec, string req);
      logic [31:0] base;
      base = 32'h0000_0120;
      ld_en = 1; ld_dec = dec; ld_ptr = base; ld_dst = 2'd3; #1;
      chk({req, " addr"}, mem_addr, dec ? base - 4 : base + 4);
      chk({req, " ptr_wb"}, ptr_wb, dec ? base - 4 : base + 4);
      step(); idle(); step();
      read_oreg({req, " data"}, 2'd3, dec ? mem[7] : mem[9]);
   endtask

   task automatic t_fused();
      logic [39:0] iv, e;
      iv = 40'h0f_f731_55aa;
      wr_oreg(2'd1, 32'hf731_5a5a);
      set_acc(iv);
      e = iv + prod40(32'hf731_5a5a, 32'ha5a5_137f, 1'b1, 1'b0);
      mul_en = 1; mul_op = 2'd1; x_use_oreg = 1; x_oreg_idx = 2'd1; x_hi = 1;
      y_use_oreg = 0; y_gpr = 32'ha5a5_137f; y_hi = 0;
      ld_en = 1; ld_dec = 0; ld_ptr = 32'h0000_0124; ld_dst = 2'd1;
      step(); idle(); x_use_oreg = 0;
      chk_acc("R11 fused uses old oreg", e);
      step();
      read_oreg("R11 fused load result", 2'd1, mem[10]);
   endtask

   task automatic t_prio();
      ld_en = 1; ld_dec = 0; ld_ptr = 32'h0000_0100; ld_dst = 2'd0; step();
      ld_en = 0; oreg_we = 1; oreg_widx = 2'd0; oreg_wdata = 32'hcafe_f00d; step();
      idle();
      read_oreg("R13 load beats direct write", 2'd0, mem[1]);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 32'h1234_5678 ^ (32'h0101_0101 * i);
      mem[10] = 32'h1234_5678;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_mul_all("R4 set gpr", 2'd0, 0, 0, 32'hf731_5a5a, 32'ha5a5_137f, 40'h0);
      t_mul_all("R5 add gpr", 2'd1, 0, 0, 32'hf731_5a5a, 32'ha5a5_137f, 40'hff_f731_55aa);
      wr_oreg(2'd1, 32'hf731_5a5a);
      wr_oreg(2'd2, 32'ha5a5_137f);
      t_mul_all("R6 R8 sub oreg", 2'd2, 1, 1, 32'hf731_5a5a, 32'ha5a5_137f, 40'h0f_f731_55aa);
      t_mul_all("R8 R2 add mixed", 2'd1, 1, 0, 32'hf731_5a5a, 32'h8000_7fff, 40'h0f_f731_55aa);
      t_mul_all("R3 set mixed", 2'd0, 0, 1, 32'h8000_ffff, 32'ha5a5_137f, 40'h0);
      t_hi_word();
      t_wrap();
      t_keep();
      t_load(1'b0, "R9 inc load");
      t_load(1'b1, "R10 dec load");
      t_fused();
      t_prio();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule